// File: doc/BRIEF.md
# Significand rounding and overflow-target unit

This combinational unit rounds an unpacked significand. Its two lowest bits are extra precision: the upper one is the guard bit and the lower one is the round bit. A separate sticky bit stands for every bit below them. The unit removes the two extra bits and decides, from the sign and a two-bit rounding-mode code, whether the remaining significand is incremented by one.

It returns the rounded significand and a carry-out from the increment. Two status flags go with them. One says the input could not be represented exactly. The other says the significand was incremented.

A separate output answers a question the caller asks when the exponent overflows. Given the same mode and sign, should the result become infinity or saturate at the largest finite magnitude? Exponent adjustment, renormalisation after a carry and packing into a storage format are left to the caller.

Top module: `rnd_unit`

## Requirements
- R1: The rounding-mode code is 00 for nearest with ties to even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity. Bit 1 of `sig_in` is the guard bit and bit 0 is the round bit. When no increment happens, `sig_out` equals `sig_in` shifted right by two and `carry_out` is 0.
- R2: When guard, round and sticky are all zero, `sig_out` is `sig_in` shifted right by two, and `inexact_o` and `rounded_up_o` are both 0, in every mode.
- R3: When any of guard, round or sticky is 1, `inexact_o` is 1 in every mode.
- R4: In nearest mode (00) an increment happens only when guard is 1 and at least one of round, sticky or bit 0 of the shifted significand is 1. An exact halfway case therefore goes to the even neighbour.
- R5: In toward-zero mode (01) no increment ever happens.
- R6: In toward-plus-infinity mode (10), an inexact input is incremented when `sign_in` is 0 (positive) and not incremented when `sign_in` is 1.
- R7: In toward-minus-infinity mode (11), an inexact input is incremented when `sign_in` is 1 and not incremented when `sign_in` is 0.
- R8: Whenever an increment happens, `rounded_up_o` is 1 and the increment carries across the whole significand. An all-ones significand becomes all zeros, with `carry_out` set to 1.
- R9: `ovf_to_inf_o` is 1 in nearest mode and 0 in toward-zero mode. Toward plus infinity it is 1 only for `sign_in` = 0, and toward minus infinity it is 1 only for `sign_in` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_in | input | SIG_W+2 | Significand; bit 1 is the guard bit, bit 0 is the round bit |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 for negative |
| mode_in | input | 2 | Rounding-mode code |
| sig_out | output | SIG_W | Rounded significand |
| carry_out | output | 1 | Carry out of the increment |
| inexact_o | output | 1 | Input was not exactly representable |
| rounded_up_o | output | 1 | Significand was incremented |
| ovf_to_inf_o | output | 1 | On overflow, go to infinity (1) or to the largest finite magnitude (0) |

## Verification
The unit holds no state, so a wrong internal decision shows at the ports as soon as the inputs settle. Such a decision appears as a `sig_out` off by one in the last place, or as a status flag that disagrees with the change in the significand. The directed cases cover each mode with each sign, and separate guard-only ties from ties broken by round or sticky. A carry that stops short of the top bit only shows on an all-ones significand, so that case is driven explicitly and `carry_out` is checked with it.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      guard_i,
  input  logic      round_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      inc_o,
  output logic      inexact_o
);

  logic lost;
  logic inc_d;

  always_comb begin
    lost = guard_i | round_i | sticky_i;
    inc_d = 1'b0;
    if (lost) begin
      unique case (mode_i)
        RM_NEAR: inc_d = guard_i & (round_i | sticky_i | lsb_i);
        RM_ZERO: inc_d = 1'b0;
        RM_PINF: inc_d = ~sign_i;
        RM_NINF: inc_d = sign_i;
        default: inc_d = 1'b0;
      endcase
    end
    inc_o     = inc_d;
    inexact_o = lost;

    AST_UP_NEEDS_INEXACT: assert (!inc_d || lost);                   // R8
    AST_ZERO_NEVER_UP:    assert (!(mode_i == RM_ZERO && inc_d));    // R5
    AST_PINF_NEG_HOLD:    assert (!(mode_i == RM_PINF && sign_i && inc_d));  // R6
    AST_NINF_POS_HOLD:    assert (!(mode_i == RM_NINF && !sign_i && inc_d)); // R7
    AST_NEAR_NEEDS_GUARD: assert (!(mode_i == RM_NEAR && inc_d && !guard_i)); // R4
  end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int  W      = 24,
  parameter bit  RIPPLE = 1'b1
) (
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] sum_full;

  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = inc_i;
      for (genvar b = 0; b < W; b++) begin : g_bit
        assign sum_full[b] = val_i[b] ^ cy[b];
        assign cy[b+1]     = val_i[b] & cy[b];
      end
      assign sum_full[W] = cy[W];
    end else begin : g_adder
      assign sum_full = {1'b0, val_i} + {{W{1'b0}}, inc_i};
    end
  endgenerate

  always_comb begin
    sum_o  = sum_full[W-1:0];
    cout_o = sum_full[W];
    AST_NO_INC_PASS: assert (inc_i || (sum_full == {1'b0, val_i}));  // R1
    AST_CARRY_ALL_ONES: assert (!sum_full[W] || (inc_i && (&val_i))); // R8
  end

endmodule

// File: rtl/rnd_ovf.sv
module rnd_ovf
  import rnd_pkg::*;
(
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      to_inf_o
);

  always_comb begin
    unique case (mode_i)
      RM_NEAR: to_inf_o = 1'b1;
      RM_ZERO: to_inf_o = 1'b0;
      RM_PINF: to_inf_o = ~sign_i;
      RM_NINF: to_inf_o = sign_i;
      default: to_inf_o = 1'b1;
    endcase
    AST_ZERO_FINITE: assert (!(mode_i == RM_ZERO && to_inf_o)); // R9
  end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int SIG_W  = 24,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [SIG_W+1:0] sig_in,
  input  logic             sticky_in,
  input  logic             sign_in,
  input  logic [1:0]       mode_in,
  output logic [SIG_W-1:0] sig_out,
  output logic             carry_out,
  output logic             inexact_o,
  output logic             rounded_up_o,
  output logic             ovf_to_inf_o
);

  localparam int IN_W = SIG_W + 2;

  rnd_mode_e        mode;
  logic [SIG_W-1:0] shifted;
  logic             guard;
  logic             rbit;
  logic             inc;

  assign mode    = rnd_mode_e'(mode_in);
  assign shifted = sig_in[IN_W-1:2];
  assign guard   = sig_in[1];
  assign rbit    = sig_in[0];

  rnd_decide u_decide (
    .guard_i   (guard),
    .round_i   (rbit),
    .sticky_i  (sticky_in),
    .lsb_i     (shifted[0]),
    .sign_i    (sign_in),
    .mode_i    (mode),
    .inc_o     (inc),
    .inexact_o (inexact_o)
  );

  rnd_incr #(.W(SIG_W), .RIPPLE(RIPPLE)) u_incr (
    .val_i  (shifted),
    .inc_i  (inc),
    .sum_o  (sig_out),
    .cout_o (carry_out)
  );

  rnd_ovf u_ovf (
    .sign_i   (sign_in),
    .mode_i   (mode),
    .to_inf_o (ovf_to_inf_o)
  );

  assign rounded_up_o = inc;

endmodule

// File: tb/rnd_unit_test.sv
module rnd_unit_test;

  localparam int W = 24;

  logic         clk;
  logic [W+1:0] sig_in;
  logic         sticky_in;
  logic         sign_in;
  logic [1:0]   mode_in;
  logic [W-1:0] sig_out;
  logic         carry_out;
  logic         inexact_o;
  logic         rounded_up_o;
  logic         ovf_to_inf_o;

  int checks = 0;
  int errors = 0;

  rnd_unit #(.SIG_W(W)) uut (
    .sig_in       (sig_in),
    .sticky_in    (sticky_in),
    .sign_in      (sign_in),
    .mode_in      (mode_in),
    .sig_out      (sig_out),
    .carry_out    (carry_out),
    .inexact_o    (inexact_o),
    .rounded_up_o (rounded_up_o),
    .ovf_to_inf_o (ovf_to_inf_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, sample one edge later away from it.
  task automatic apply(input logic [W-1:0] s, input logic g, input logic r,
                       input logic st, input logic sg, input logic [1:0] m);
    @(negedge clk);
    sig_in = {s, g, r}; sticky_in = st; sign_in = sg; mode_in = m;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_round(input string tag, input logic [W-1:0] v,
                              input logic c, input logic ix, input logic up);
    chk({tag, " sig"}, 32'(sig_out), 32'(v));
    chk({tag, " carry"}, 32'(carry_out), 32'(c));
    chk({tag, " inexact"}, 32'(inexact_o), 32'(ix));
    chk({tag, " up"}, 32'(rounded_up_o), 32'(up));
  endtask

  task automatic t_exact;
    for (int m = 0; m < 4; m++) begin
      apply(24'h123456, 1'b0, 1'b0, 1'b0, m[0], 2'(m));
      expect_round("R2 exact", 24'h123456, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_near;
    apply(24'h000002, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    expect_round("R4 tie even", 24'h000002, 1'b0, 1'b1, 1'b0);
    apply(24'h000003, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    expect_round("R4 tie odd", 24'h000004, 1'b0, 1'b1, 1'b1);
    apply(24'h000002, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00);
    expect_round("R4 above half round", 24'h000003, 1'b0, 1'b1, 1'b1);
    apply(24'h000002, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
    expect_round("R4 above half sticky", 24'h000003, 1'b0, 1'b1, 1'b1);
    apply(24'h000003, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
    expect_round("R4 below half", 24'h000003, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_zero;
    apply(24'h7ABCDE, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01);
    expect_round("R5 pos", 24'h7ABCDE, 1'b0, 1'b1, 1'b0);
    apply(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01);
    expect_round("R5 neg", 24'hFFFFFF, 1'b0, 1'b1, 1'b0);
    apply(24'h000010, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01);
    expect_round("R3 sticky only", 24'h000010, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_pinf;
    apply(24'h000010, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10);
    expect_round("R6 pos", 24'h000011, 1'b0, 1'b1, 1'b1);
    apply(24'h000010, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10);
    expect_round("R6 neg", 24'h000010, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_ninf;
    apply(24'h000FFF, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11);
    expect_round("R7 neg", 24'h001000, 1'b0, 1'b1, 1'b1);
    apply(24'h000FFF, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11);
    expect_round("R7 pos", 24'h000FFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_carry;
    apply(24'hFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
    expect_round("R8 full carry", 24'h000000, 1'b1, 1'b1, 1'b1);
    apply(24'hFFFFFE, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
    expect_round("R1 no carry out", 24'hFFFFFF, 1'b0, 1'b1, 1'b1);
    apply(24'h7FFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
    expect_round("R8 carry to top", 24'h800000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_ovf;
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00); chk("R9 near pos", 32'(ovf_to_inf_o), 32'd1);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00); chk("R9 near neg", 32'(ovf_to_inf_o), 32'd1);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01); chk("R9 zero pos", 32'(ovf_to_inf_o), 32'd0);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01); chk("R9 zero neg", 32'(ovf_to_inf_o), 32'd0);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10); chk("R9 pinf pos", 32'(ovf_to_inf_o), 32'd1);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10); chk("R9 pinf neg", 32'(ovf_to_inf_o), 32'd0);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11); chk("R9 ninf pos", 32'(ovf_to_inf_o), 32'd0);
    apply(24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11); chk("R9 ninf neg", 32'(ovf_to_inf_o), 32'd1);
  endtask

  initial begin
    fork
      begin
        sig_in = '0; sticky_in = 1'b0; sign_in = 1'b0; mode_in = 2'b00;
        #2;
        expect_round("R2 idle zero", 24'h000000, 1'b0, 1'b0, 1'b0);
        t_exact;
        t_near;
        t_zero;
        t_pinf;
        t_ninf;
        t_carry;
        t_ovf;
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule